// File: doc/BRIEF.md
# Subtract-From Execute Unit

This block executes one register-register "subtract from" instruction per clock. It receives a 32-bit instruction word and the two source operand values, checks that the word carries the subtract-from encoding, and computes the second operand minus the first by complementing the first operand and adding it with a carry-in of one. The difference is written back to the destination register index given in the word, through a write strobe, one clock later.

The unit also holds the status state that the instruction can touch. This is an overflow bit and a sticky summary-overflow bit, plus a 4-bit condition field. The overflow-enable flag in the word decides whether signed overflow is recorded. The record flag decides whether the condition field is rewritten from a signed comparison of the result with zero. Words with another opcode are reported on an illegal-instruction strobe and have no effect. A synchronous clear input models software clearing the overflow bits.

Top module: `subf_exec_unit`

## Requirements
- R1: An instruction is accepted when `in_valid` is 1, bits 31:26 of `in_insn` equal 31 and bits 9:1 equal 40. The field layout is: destination index in bits 25:21, operand-A register in bits 20:16, operand-B register in bits 15:11, overflow-enable in bit 10 and record flag in bit 0. Any other word with `in_valid` 1 raises `out_illegal` for exactly one cycle, does not assert `out_wr_en`, and leaves `xer_ov`, `xer_so` and `cr0` unchanged.
- R2: For an accepted instruction, `out_wr_en` is 1 in the cycle after acceptance. In that cycle `out_wr_idx` equals the destination field and `out_wr_data` equals (`in_src_b` − `in_src_a`) modulo 2^XLEN. This happens whatever the flags are.
- R3: When overflow-enable is 1, `xer_ov` becomes 1 exactly when the signed difference B − A falls outside the XLEN-bit signed range. Otherwise it becomes 0.
- R4: When overflow-enable is 1, `xer_so` becomes its previous value OR the new overflow bit. It is never cleared by an instruction.
- R5: When overflow-enable is 0, an accepted instruction changes neither `xer_ov` nor `xer_so`.
- R6: When the record flag is 1, `cr0` is written as {LT, GT, EQ, SO} in bits 3..0. LT, GT and EQ come from a signed comparison of the result with zero, and SO is the value `xer_so` takes after this instruction. When the record flag is 0, `cr0` is unchanged.
- R7: `ovf_clear` set to 1 clears `xer_ov` and `xer_so` at the next edge. If an accepted instruction with overflow-enable 1 arrives in the same cycle, its overflow update is applied after the clear.
- R8: After reset, `out_wr_en`, `out_illegal`, `xer_ov`, `xer_so` and `cr0` are all 0.
- R9: While `in_valid` is 0, `out_wr_en` and `out_illegal` are 0 and the status state holds, apart from the effect of `ovf_clear`.
- R10: Back-to-back instructions see each other's status. The SO copied into `cr0` includes overflow recorded by the instruction one cycle earlier.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| in_insn | input | 32 | Instruction word |
| in_src_a | input | XLEN | Value of operand-A register (subtrahend) |
| in_src_b | input | XLEN | Value of operand-B register (minuend) |
| ovf_clear | input | 1 | Clear overflow and summary-overflow bits |
| out_wr_en | output | 1 | Register write strobe |
| out_wr_idx | output | 5 | Destination register index |
| out_wr_data | output | XLEN | Difference to write |
| out_illegal | output | 1 | Non-matching word was presented |
| xer_ov | output | 1 | Overflow bit |
| xer_so | output | 1 | Sticky summary-overflow bit |
| cr0 | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The bench builds the unit with XLEN set to 8. This makes the complete cross product of both operands, 65,536 pairs, affordable in one run. Every signed-overflow boundary, every zero result and every sign combination is therefore reached, not sampled. The overflow-enable flag, the record flag, the destination index and occasional clears are derived from the operand values. This mixes sticky-bit histories with back-to-back record forms. Directed steps then cover illegal words, the clear colliding with an overflowing instruction, and idle cycles.

// File: rtl/subf_pkg.sv
package subf_pkg;

   localparam int unsigned INSN_W   = 32;
   localparam int unsigned REGIDX_W = 5;
   localparam int unsigned PRIM_OP  = 31;
   localparam int unsigned EXT_OP   = 40;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } cond_field_t;

   typedef struct packed {
      logic                match;
      logic [REGIDX_W-1:0] dst;
      logic [REGIDX_W-1:0] reg_a;
      logic [REGIDX_W-1:0] reg_b;
      logic                ovf_en;
      logic                rec;
   } insn_fields_t;

endpackage

// File: rtl/subf_decode.sv
module subf_decode
   import subf_pkg::*;
(
   input  logic [INSN_W-1:0] insn,
   output insn_fields_t      fields
);
   localparam int unsigned PRIM_HI = INSN_W - 1;
   localparam int unsigned PRIM_LO = INSN_W - 6;
   localparam int unsigned XO_HI   = 9;
   localparam int unsigned XO_LO   = 1;

   logic prim_hit;
   logic ext_hit;

   always_comb begin
      prim_hit      = (insn[PRIM_HI:PRIM_LO] == 6'(PRIM_OP));
      ext_hit       = (insn[XO_HI:XO_LO] == 9'(EXT_OP));
      fields.match  = prim_hit && ext_hit;
      fields.dst    = insn[25:21];
      fields.reg_a  = insn[20:16];
      fields.reg_b  = insn[15:11];
      fields.ovf_en = insn[10];
      fields.rec    = insn[0];
   end
endmodule

// File: rtl/subf_datapath.sv
module subf_datapath
   import subf_pkg::*;
#(
   parameter int unsigned XLEN          = 32,
   parameter bit          OV_FROM_CARRY = 1'b0
)(
   input  logic [XLEN-1:0] src_a,
   input  logic [XLEN-1:0] src_b,
   output logic [XLEN-1:0] diff,
   output logic            ovf,
   output logic            is_neg,
   output logic            is_zero
);
   localparam int unsigned MSB = XLEN - 1;

   logic [XLEN-1:0] a_inv;
   logic [XLEN:0]   full_sum;

   always_comb begin
      a_inv    = ~src_a;
      full_sum = {1'b0, a_inv} + {1'b0, src_b} + {{XLEN{1'b0}}, 1'b1};
      diff     = full_sum[MSB:0];
      is_neg   = diff[MSB];
      is_zero  = (diff == '0);
   end

   generate
      if (OV_FROM_CARRY) begin : g_ov_carry
         logic [MSB:0] low_sum;
         always_comb begin
            low_sum = {1'b0, a_inv[MSB-1:0]} + {1'b0, src_b[MSB-1:0]}
                      + {{MSB{1'b0}}, 1'b1};
            ovf     = low_sum[MSB] ^ full_sum[XLEN];
         end
      end else begin : g_ov_sign
         always_comb begin
            ovf = (src_a[MSB] ^ src_b[MSB]) & (src_b[MSB] ^ diff[MSB]);
         end
      end
   endgenerate
endmodule

// File: rtl/subf_status.sv
module subf_status
   import subf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        upd,
   input  logic        ovf_en,
   input  logic        rec,
   input  logic        ovf_new,
   input  logic        res_neg,
   input  logic        res_zero,
   input  logic        clr,
   output logic        ov_q,
   output logic        so_q,
   output cond_field_t cr_q
);
   logic        ov_base;
   logic        so_base;
   logic        ov_d;
   logic        so_d;
   cond_field_t cr_d;

   always_comb begin
      ov_base = clr ? 1'b0 : ov_q;
      so_base = clr ? 1'b0 : so_q;
      ov_d    = ov_base;
      so_d    = so_base;
      cr_d    = cr_q;
      if (upd && ovf_en) begin
         ov_d = ovf_new;
         so_d = so_base | ovf_new;
      end
      if (upd && rec) begin
         cr_d.lt = res_neg;
         cr_d.gt = !res_neg && !res_zero;
         cr_d.eq = res_zero;
         cr_d.so = so_d;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ov_q <= 1'b0;
         so_q <= 1'b0;
         cr_q <= '0;
      end else begin
         ov_q <= ov_d;
         so_q <= so_d;
         cr_q <= cr_d;
      end
   end
endmodule

// File: rtl/subf_exec_unit.sv
module subf_exec_unit
   import subf_pkg::*;
#(
   parameter int unsigned XLEN          = 32,
   parameter bit          OV_FROM_CARRY = 1'b0
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [31:0]     in_insn,
   input  logic [XLEN-1:0] in_src_a,
   input  logic [XLEN-1:0] in_src_b,
   input  logic            ovf_clear,
   output logic            out_wr_en,
   output logic [4:0]      out_wr_idx,
   output logic [XLEN-1:0] out_wr_data,
   output logic            out_illegal,
   output logic            xer_ov,
   output logic            xer_so,
   output logic [3:0]      cr0
);
   initial begin
      assert (XLEN >= 2)
         else $error("subf_exec_unit: XLEN must be at least 2");
      assert (INSN_W == 32 && REGIDX_W == 5)
         else $error("subf_exec_unit: instruction layout mismatch");
   end

   insn_fields_t    fld;
   logic [XLEN-1:0] diff;
   logic            ovf;
   logic            neg;
   logic            zero;
   logic            accept;
   logic            reject;
   cond_field_t     cr_q;

   subf_decode u_dec (
      .insn   (in_insn),
      .fields (fld)
   );

   subf_datapath #(
      .XLEN          (XLEN),
      .OV_FROM_CARRY (OV_FROM_CARRY)
   ) u_dp (
      .src_a   (in_src_a),
      .src_b   (in_src_b),
      .diff    (diff),
      .ovf     (ovf),
      .is_neg  (neg),
      .is_zero (zero)
   );

   always_comb begin
      accept = in_valid && fld.match;
      reject = in_valid && !fld.match;
   end

   subf_status u_st (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (accept),
      .ovf_en   (fld.ovf_en),
      .rec      (fld.rec),
      .ovf_new  (ovf),
      .res_neg  (neg),
      .res_zero (zero),
      .clr      (ovf_clear),
      .ov_q     (xer_ov),
      .so_q     (xer_so),
      .cr_q     (cr_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_wr_en   <= 1'b0;
         out_illegal <= 1'b0;
         out_wr_idx  <= '0;
         out_wr_data <= '0;
      end else begin
         out_wr_en   <= accept;
         out_illegal <= reject;
         if (accept) begin
            out_wr_idx  <= fld.dst;
            out_wr_data <= diff;
         end
      end
   end

   assign cr0 = cr_q;
endmodule

// File: rtl/subf_exec_unit_chk.sv
module subf_exec_unit_chk #(
   parameter int unsigned XLEN = 32
)(
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            ovf_clear,
   input logic            out_wr_en,
   input logic            out_illegal,
   input logic            xer_ov,
   input logic            xer_so,
   input logic [3:0]      cr0
);
   // R1
   illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> !out_wr_en);

   // R4
   so_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xer_so && !ovf_clear) |=> xer_so);

   // R4
   ov_implies_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xer_ov |-> xer_so);

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !ovf_clear) |=> ($stable(xer_ov) && $stable(xer_so) && $stable(cr0)));

   // R9
   idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_wr_en && !out_illegal));

   // R6
   cmp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cr0[3:1]));

   // R6
   cr_so_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cr0 != $past(cr0)) |-> (cr0[0] == xer_so));

   // R7
   clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_clear && !in_valid) |=> (!xer_ov && !xer_so));
endmodule

bind subf_exec_unit subf_exec_unit_chk #(.XLEN(XLEN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .ovf_clear   (ovf_clear),
   .out_wr_en   (out_wr_en),
   .out_illegal (out_illegal),
   .xer_ov      (xer_ov),
   .xer_so      (xer_so),
   .cr0         (cr0)
);

// File: tb/subf_exec_unit_test.sv
`timescale 1ns/1ps
module subf_exec_unit_test;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [31:0]  in_insn = '0;
   logic [W-1:0] in_src_a = '0;
   logic [W-1:0] in_src_b = '0;
   logic         ovf_clear = 1'b0;
   logic         out_wr_en;
   logic [4:0]   out_wr_idx;
   logic [W-1:0] out_wr_data;
   logic         out_illegal;
   logic         xer_ov;
   logic         xer_so;
   logic [3:0]   cr0;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   logic       m_ov = 1'b0;
   logic       m_so = 1'b0;
   logic [3:0] m_cr = 4'b0;

   always #4 clk = ~clk;

   subf_exec_unit #(.XLEN(W)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
      .in_src_a(in_src_a), .in_src_b(in_src_b), .ovf_clear(ovf_clear),
      .out_wr_en(out_wr_en), .out_wr_idx(out_wr_idx), .out_wr_data(out_wr_data),
      .out_illegal(out_illegal), .xer_ov(xer_ov), .xer_so(xer_so), .cr0(cr0)
   );

   function automatic logic [31:0] mk(input logic [4:0] rt, input logic oe, input logic rc);
      return {6'd31, rt, 5'd3, 5'd4, oe, 9'd40, rc};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic state_check(input string req);
      check(req, {28'd0, xer_ov, xer_so, 2'b0} | {28'd0, cr0} << 4,
                 {28'd0, m_ov, m_so, 2'b0} | {28'd0, m_cr} << 4);
   endtask

   // one accepted op: drive at negedge, sample 1 ns after the next posedge
   task automatic run_op(input int a, input int b, input logic [4:0] rt,
                         input logic oe, input logic rc, input logic clr, input string req);
      int sa;
      int sb;
      int d;
      logic ovn;
      logic [W-1:0] res;
      @(negedge clk);
      in_valid  = 1'b1;
      in_insn   = mk(rt, oe, rc);
      in_src_a  = W'(a);
      in_src_b  = W'(b);
      ovf_clear = clr;
      sa  = (a >= 128) ? a - 256 : a;
      sb  = (b >= 128) ? b - 256 : b;
      d   = sb - sa;
      ovn = (d > 127) || (d < -128);
      res = W'(b - a);
      if (clr) begin m_ov = 1'b0; m_so = 1'b0; end
      if (oe) begin m_ov = ovn; m_so = m_so | ovn; end
      if (rc) m_cr = {res[W-1], !res[W-1] && (res != 0), res == 0, m_so};
      @(posedge clk);
      #1;
      in_valid  = 1'b0;
      ovf_clear = 1'b0;
      check({req, " R2 write"}, {out_illegal, out_wr_en, out_wr_idx, out_wr_data},
            {1'b0, 1'b1, rt, res});
      state_check({req, " R3/R4/R5/R6 status"});
   endtask

   initial begin : watchdog
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1;
      // R8 reset state
      check("R8 reset", {out_wr_en, out_illegal, xer_ov, xer_so, cr0}, 8'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R9 idle: nothing moves
      repeat (2) @(posedge clk);
      #1;
      check("R9 idle strobes", {out_wr_en, out_illegal}, 2'b0);
      state_check("R9 idle hold");

      // exhaustive sweep, flags from operands (R2 R3 R4 R5 R6 R10)
      for (int a = 0; a < 256; a++) begin
         for (int b = 0; b < 256; b++) begin
            run_op(a, b, 5'((a + 3 * b) & 31), ((a + b) % 3) != 0,
                   ((a ^ b) & 1) == 1, ((a * 7 + b) % 97) == 0, "sweep");
         end
      end

      // R10 back-to-back: overflow then record form without OE
      run_op(0, 0, 5'd1, 1'b0, 1'b0, 1'b1, "R7 clear");
      check("R7 cleared", {30'd0, xer_ov, xer_so}, 32'd0);
      run_op(1, 128, 5'd2, 1'b1, 1'b0, 1'b0, "R3 ovf");
      check("R3 ovf set", {30'd0, xer_ov, xer_so}, 32'd3);
      run_op(5, 5, 5'd7, 1'b0, 1'b1, 1'b0, "R10 b2b");
      check("R10 cr0 so", {28'd0, cr0}, 32'b0011);

      // R5 OE=0 with non-overflowing op leaves ov set
      run_op(2, 1, 5'd9, 1'b0, 1'b0, 1'b0, "R5 hold");
      check("R5 ov kept", {30'd0, xer_ov, xer_so}, 32'd3);
      // R4 OE=1 without overflow: ov clears, so sticks
      run_op(2, 1, 5'd9, 1'b1, 1'b1, 1'b0, "R4 sticky");
      check("R4 so sticky", {28'd0, xer_ov, xer_so, cr0[3], cr0[0]}, 32'b0111);

      // R7 clear with overflowing OE op in the same cycle
      run_op(255, 127, 5'd4, 1'b1, 1'b1, 1'b1, "R7 clear+ovf");
      check("R7 ovf after clear", {30'd0, xer_ov, xer_so}, 32'd3);
      run_op(0, 0, 5'd4, 1'b0, 1'b0, 1'b1, "R7 clear");
      run_op(3, 3, 5'd4, 1'b0, 1'b1, 1'b1, "R7 clear+rec");
      check("R7 cr0 so after clear", {28'd0, cr0}, 32'b0010);

      // R1 illegal words: wrong primary, wrong extended opcode
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_src_a = 8'h01;
         in_src_b = 8'h80;
         case (k)
            0: in_insn = {6'd30, 5'd1, 5'd0, 5'd0, 1'b1, 9'd40, 1'b1};
            1: in_insn = {6'd31, 5'd1, 5'd0, 5'd0, 1'b1, 9'd8, 1'b1};
            default: in_insn = {6'd31, 5'd1, 5'd0, 5'd0, 1'b1, 9'd41, 1'b1};
         endcase
         @(posedge clk);
         #1;
         in_valid = 1'b0;
         check("R1 illegal strobe", {30'd0, out_illegal, out_wr_en}, 32'd2);
         state_check("R1 no status change");
         @(posedge clk);
         #1;
         check("R1 one cycle", {31'd0, out_illegal}, 32'd0);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule